// File: doc/BRIEF.md
# Address-Encoded Message Interrupt Controller

This block receives message-signalled interrupts as plain bus writes into a fixed address window. The address alone carries the meaning: one address field names the destination processor, another names the interrupt vector, and a fixed tag in the top bits identifies the window. The write data is discarded. For each processor the block holds a 256-bit pending vector. An accepted write sets one bit in it. Each processor's request line is high while any of its pending bits is set.

Each core acknowledges a vector through a clear port, which gives a processor index, a vector and a strobe. Delivery is gated twice. A strap input says whether the feature exists at all. A software enable bit can be set only while the feature exists, and it drops when the feature is withdrawn. A monitor port exposes one processor's pending vector, which models the status register that processor reads.

Top module: `msgirq_router`

## Requirements
- R1: A delivered write sets pending bit `bus_addr[11:4]` of processor `bus_addr[19:12]`. Bits [27:20] and [3:0] of the address are don't-care.
- R2: The write data has no effect, and a delivered write leaves every other pending bit of every processor unchanged.
- R3: A write whose `bus_addr[39:28]` differs from parameter `WIN_TAG` (default 12'h2FE) changes no pending bit and raises no error.
- R4: `bus_rdata` is always zero, and a read changes no pending bit.
- R5: `irq_o[i]` is the OR of processor i's pending bits. It goes high on the cycle after the delivering write's clock edge.
- R6: Delivery needs `feat_present` high and the enable `cfg_en` set. A `cfg_wr` with `cfg_wdata[0]`=1 sets the enable only while `feat_present` is high. Writing 0 does not clear it. `feat_present` low clears it at the next edge.
- R7: A delivered-window write whose processor number is NUM_CPU or more is dropped and pulses `err_o` high for exactly one cycle.
- R8: A `clr_valid` strobe clears bit `clr_vec` of processor `clr_cpu` at the next edge, and the request line falls once the last bit is gone.
- R9: When a write and a clear target the same bit in the same cycle, the bit ends up set.
- R10: Synchronous reset clears all pending bits, the enable, `err_o` and all request lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_present | input | 1 | Feature-available strap |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control write data, bit 0 requests enable |
| cfg_en | output | 1 | Current delivery enable |
| bus_addr | input | ADDR_W (40) | Window access address |
| bus_wr | input | 1 | Window write strobe |
| bus_rd | input | 1 | Window read strobe |
| bus_wdata | input | 32 | Write data (ignored) |
| bus_rdata | output | 32 | Read data, always zero |
| clr_valid | input | 1 | Acknowledge strobe |
| clr_cpu | input | 8 | Processor to acknowledge for |
| clr_vec | input | 8 | Vector to clear |
| mon_cpu | input | 8 | Processor whose pending vector is shown |
| mon_pending | output | 256 | Pending vector of `mon_cpu`, zero if out of range |
| irq_o | output | NUM_CPU | Per-processor request lines |
| err_o | output | 1 | One-cycle pulse on an out-of-range processor |

## Verification
The hardest case to reach is a same-cycle collision of an incoming write and an acknowledge on one bit. The clear port and the window port are independent, so the bench drives both strobes together in one task and checks that the bit survives. The enable's set-only and strap-dependent behaviour also needs care. The bench first tries to enable with the strap low, then writes a zero to show that the enable stays set. It then drops the strap and shows that a later write is lost.

// File: rtl/msgirq_pkg.sv
package msgirq_pkg;
    localparam int VEC_W    = 8;
    localparam int CPU_W    = 8;
    localparam int NUM_VEC  = 1 << VEC_W;
    localparam int VEC_LSB  = 4;
    localparam int CPU_LSB  = 12;
    localparam int TAG_LSB  = 28;
    localparam int TAG_W    = 12;
    localparam int EN_BIT   = 0;

    typedef struct packed {
        logic en;
        logic err;
    } ctl_st_t;
endpackage

// File: rtl/msgirq_decode.sv
module msgirq_decode
    import msgirq_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int NUM_CPU  = 4,
    parameter logic [TAG_W-1:0] WIN_TAG = 12'h2FE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              deliver_ok,
    output logic              set_stb,
    output logic [CPU_W-1:0]  set_cpu,
    output logic [VEC_W-1:0]  set_vec,
    output logic              bad_cpu
);
    logic tag_hit;
    logic in_range;
    logic unused_bits;

    assign unused_bits = ^{addr[TAG_LSB-1:CPU_LSB+CPU_W], addr[VEC_LSB-1:0]};

    always_comb begin
        tag_hit  = (addr[TAG_LSB +: TAG_W] == WIN_TAG);
        set_cpu  = addr[CPU_LSB +: CPU_W];
        set_vec  = addr[VEC_LSB +: VEC_W];
        in_range = ({1'b0, set_cpu} < (CPU_W+1)'(NUM_CPU));
        set_stb  = wr && tag_hit && deliver_ok && in_range;
        bad_cpu  = wr && tag_hit && deliver_ok && !in_range;
    end
endmodule

// File: rtl/msgirq_ctl.sv
module msgirq_ctl
    import msgirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        feat_present,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        bad_cpu,
    output logic        en_q,
    output logic        err_q
);
    ctl_st_t st_d, st_q;
    logic    unused_cfg;

    assign unused_cfg = ^{cfg_wdata[31:EN_BIT+1]};

    always_comb begin
        st_d     = st_q;
        st_d.err = bad_cpu;
        if (!feat_present)
            st_d.en = 1'b0;
        else if (cfg_wr && cfg_wdata[EN_BIT])
            st_d.en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign en_q  = st_q.en;
    assign err_q = st_q.err;

    // R6: strap removal drops the enable
    assert_strap_clears_en_R6: assert property (@(posedge clk) disable iff (rst)
        !feat_present |=> !en_q);
    // R7: error pulse only follows a bad write
    assert_err_only_after_bad_R7: assert property (@(posedge clk) disable iff (rst)
        !bad_cpu |=> !err_q);
endmodule

// File: rtl/msgirq_bank.sv
module msgirq_bank
    import msgirq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               set_stb,
    input  logic [VEC_W-1:0]   set_vec,
    input  logic               clr_stb,
    input  logic [VEC_W-1:0]   clr_vec,
    output logic [NUM_VEC-1:0] pend_q,
    output logic               irq
);
    logic [NUM_VEC-1:0] pend_d;

    always_comb begin
        pend_d = pend_q;
        if (clr_stb) pend_d[clr_vec] = 1'b0;
        if (set_stb) pend_d[set_vec] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign irq = |pend_q;

    // R1/R5: a set is visible and raises the request next cycle
    assert_set_raises_irq_R5: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> (irq && pend_q[$past(set_vec)]));
    // R9: set wins a same-bit collision
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (set_stb && clr_stb && set_vec == clr_vec) |=> pend_q[$past(set_vec)]);
    // R8: a lone clear removes its bit
    assert_clear_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_stb && !set_stb) |=> !pend_q[$past(clr_vec)]);
    // R2: without strobes nothing moves
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!set_stb && !clr_stb) |=> $stable(pend_q));
endmodule

// File: rtl/msgirq_router.sv
module msgirq_router
    import msgirq_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_CPU = 4,
    parameter logic [11:0] WIN_TAG = 12'h2FE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                feat_present,
    input  logic                cfg_wr,
    input  logic [31:0]         cfg_wdata,
    output logic                cfg_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                clr_valid,
    input  logic [7:0]          clr_cpu,
    input  logic [7:0]          clr_vec,
    input  logic [7:0]          mon_cpu,
    output logic [255:0]        mon_pending,
    output logic [NUM_CPU-1:0]  irq_o,
    output logic                err_o
);
    logic                              set_stb;
    logic [CPU_W-1:0]                  set_cpu;
    logic [VEC_W-1:0]                  set_vec;
    logic                              bad_cpu;
    logic                              en_q;
    logic [NUM_CPU-1:0][NUM_VEC-1:0]   pend_all;
    logic                              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    msgirq_decode #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .WIN_TAG(WIN_TAG)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .deliver_ok(en_q && feat_present),
        .set_stb(set_stb), .set_cpu(set_cpu), .set_vec(set_vec), .bad_cpu(bad_cpu)
    );

    msgirq_ctl u_ctl (
        .clk(clk), .rst(rst), .feat_present(feat_present), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .bad_cpu(bad_cpu), .en_q(en_q), .err_q(err_o)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_bank
        msgirq_bank u_bank (
            .clk(clk), .rst(rst),
            .set_stb(set_stb && set_cpu == CPU_W'(i)), .set_vec(set_vec),
            .clr_stb(clr_valid && clr_cpu == CPU_W'(i)), .clr_vec(clr_vec),
            .pend_q(pend_all[i]), .irq(irq_o[i])
        );
    end

    always_comb begin
        mon_pending = '0;
        for (int k = 0; k < NUM_CPU; k++)
            if (mon_cpu == CPU_W'(k)) mon_pending = pend_all[k];
    end

    assign cfg_en    = en_q;
    assign bus_rdata = '0;

    // R4: a pure read leaves the request lines alone
    assert_read_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && !clr_valid) |=> $stable(irq_o));
    // R6: nothing is delivered while disabled
    assert_no_delivery_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        (!en_q && !clr_valid) |=> $stable(irq_o));
endmodule

// File: tb/msgirq_router_tb.sv
module msgirq_router_tb_top;
    localparam int CLK_T = 10;
    localparam int NCPU  = 4;
    localparam logic [11:0] TAG = 12'h2FE;

    logic clk = 0, rst = 1, feat_present = 0, cfg_wr = 0;
    logic [31:0] cfg_wdata = 0;
    logic cfg_en;
    logic [39:0] bus_addr = 0;
    logic bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic clr_valid = 0;
    logic [7:0] clr_cpu = 0, clr_vec = 0, mon_cpu = 0;
    logic [255:0] mon_pending;
    logic [NCPU-1:0] irq_o;
    logic err_o;
    int total = 0, bad = 0;

    always #(CLK_T/2) clk = ~clk;

    msgirq_router #(.NUM_CPU(NCPU), .WIN_TAG(TAG)) dut_i (.*);

    function automatic logic [39:0] mk(input logic [11:0] t, input logic [7:0] c, input logic [7:0] v);
        return {t, 8'hA5, c, v, 4'h9};
    endfunction

    function automatic logic [255:0] bit_of(input int v);
        logic [255:0] r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

    task automatic chk(input logic [255:0] act, input logic [255:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic tick; @(posedge clk); #1; endtask

    task automatic do_write(input logic [39:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        tick(); bus_wr = 0;
    endtask

    task automatic do_clear(input int c, input int v);
        @(negedge clk); clr_cpu = 8'(c); clr_vec = 8'(v); clr_valid = 1;
        tick(); clr_valid = 0;
    endtask

    task automatic do_cfg(input logic [31:0] d);
        @(negedge clk); cfg_wdata = d; cfg_wr = 1;
        tick(); cfg_wr = 0;
    endtask

    task automatic peek(input int c, input logic [255:0] exp, input string what);
        mon_cpu = 8'(c); #1; chk(mon_pending, exp, what);
    endtask

    task automatic t_reset;
        rst = 1; tick(); tick();
        @(negedge clk); rst = 0; #1;
        chk(irq_o, 0, "R10 irq after reset");
        chk(err_o, 0, "R10 err after reset");
        chk(cfg_en, 0, "R10 enable after reset");
        peek(0, 0, "R10 pending after reset");
    endtask

    task automatic t_enable;
        feat_present = 1;
        do_write(mk(TAG, 1, 5), 0);
        peek(1, 0, "R6 no delivery while disabled");
        feat_present = 0;
        do_cfg(32'h1);
        chk(cfg_en, 0, "R6 enable refused without feature");
        feat_present = 1;
        do_cfg(32'h1);
        chk(cfg_en, 1, "R6 enable set with feature");
        do_cfg(32'h0);
        chk(cfg_en, 1, "R6 writing zero keeps enable");
    endtask

    task automatic t_deliver;
        do_write(mk(TAG, 2, 8'h37), 32'hDEADBEEF);
        chk(irq_o, 4'b0100, "R5 irq of cpu2 after write");
        peek(2, bit_of(8'h37), "R1 vector 0x37 on cpu2");
        do_write(mk(TAG, 2, 8'h00), 32'h0);
        peek(2, bit_of(8'h37) | bit_of(0), "R2 earlier bit kept, data ignored");
        peek(1, 0, "R2 other cpu untouched");
        do_write(mk(TAG, 3, 8'hFF), 32'h1234);
        peek(3, bit_of(255), "R1 top vector on cpu3");
        chk(irq_o, 4'b1100, "R5 irq of cpu2 and cpu3");
    endtask

    task automatic t_tag_and_read;
        do_write(mk(12'h2FF, 0, 8'h10), 0);
        peek(0, 0, "R3 wrong tag ignored");
        chk(err_o, 0, "R3 no error on wrong tag");
        @(negedge clk); bus_addr = mk(TAG, 0, 8'h11); bus_rd = 1; #1;
        chk(bus_rdata, 0, "R4 read data zero");
        tick(); bus_rd = 0;
        peek(0, 0, "R4 read has no side effect");
    endtask

    task automatic t_bad_cpu;
        do_write(mk(TAG, 7, 8'h02), 0);
        chk(err_o, 1, "R7 error pulse");
        chk(irq_o, 4'b1100, "R7 write dropped");
        tick();
        chk(err_o, 0, "R7 error lasts one cycle");
    endtask

    task automatic t_clear;
        do_clear(2, 8'h37);
        peek(2, bit_of(0), "R8 one bit cleared");
        chk(irq_o, 4'b1100, "R8 irq still high with bit left");
        do_clear(2, 0);
        chk(irq_o, 4'b1000, "R8 irq falls after last clear");
    endtask

    task automatic t_collide;
        @(negedge clk);
        bus_addr = mk(TAG, 1, 8'h80); bus_wr = 1;
        clr_cpu = 1; clr_vec = 8'h80; clr_valid = 1;
        tick(); bus_wr = 0; clr_valid = 0;
        peek(1, bit_of(8'h80), "R9 set wins collision");
    endtask

    task automatic t_strap_off;
        feat_present = 0; tick();
        chk(cfg_en, 0, "R6 strap off clears enable");
        feat_present = 1;
        do_write(mk(TAG, 0, 8'h03), 0);
        peek(0, 0, "R6 no delivery after enable cleared");
    endtask

    task automatic t_reset_mid;
        @(negedge clk); rst = 1; tick(); rst = 0;
        chk(irq_o, 0, "R10 reset clears irq");
        peek(1, 0, "R10 reset clears pending");
    endtask

    initial begin
        fork
            begin
                t_reset(); t_enable(); t_deliver(); t_tag_and_read();
                t_bad_cpu(); t_clear(); t_collide(); t_strap_off(); t_reset_mid();
            end
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule